// File: doc/BRIEF.md
# Burst-Addressed Dual-Port Synchronous RAM

This block is a true dual-port synchronous static RAM with two independent ports, left and right. It holds words of 18 bits and is sized for the 8K-word configuration when `AW` is set to 13. The elaborated default is `AW = 11`, which gives 2K words. Both ports run on a shared clock. Either port can read or write any word, and both ports may use the same word in the same cycle. Every input is sampled at the rising clock edge.

Each port has its own burst address counter, so a host can stream through consecutive words without presenting every address. Each cycle the counter is cleared, loaded from the external address, incremented or held. The result of that choice is the address the port uses in that cycle, and it is also the value the counter keeps. A port is enabled by a pair of chip enables, one active low and one active high. Its two 9-bit byte lanes are gated separately, and an output enable marks the read data valid without stalling the read path. A static mode pin selects the read timing: flow-through, with data after the capturing edge, or pipelined, with one extra register stage.

Top module: `burst_dpram`

## Requirements
- R1: The array holds 2^AW words of 18 bits. Both ports may read or write any word in the same cycle, including the same word.
- R2: The counter controls are active low, with this priority: clear (`*_clr_n`) first, then load (`*_ld_n`), then increment (`*_inc_n`). With none asserted, the counter holds.
- R3: In a load cycle the access uses the external address. Otherwise it uses the counter: the held value, or the held value plus one when incrementing. The counter then keeps the address that was used.
- R4: A clear costs no cycle. An access in the clear cycle goes to word 0, and the next incrementing access goes to word 1.
- R5: Incrementing from word 2^AW-1 wraps the counter to word 0.
- R6: With `pipe_mode` = 0, data read at a capturing edge is on `*_rdata` with `*_rvalid` = 1 right after that same edge.
- R7: With `pipe_mode` = 1, the read data and its valid flag appear one edge later than in R6.
- R8: A port is selected only when `*_en_n` = 0 and `*_en2` = 1. A deselected cycle writes nothing and yields no valid read. In pipelined mode, the invalid output shows after the following edge.
- R9: `*_hi_n` gates bits 17:9 and `*_lo_n` gates bits 8:0, both active low. A disabled lane is not written, and it reads as zero.
- R10: `*_oe_n` = 1, sampled at the edge that updates the output, forces `*_rvalid` to 0. The read pipeline still advances.
- R11: When both ports write the same word in one cycle, the left port's data is stored in every lane both ports enable. A read issued in the same cycle as a write returns the old data. The new data is readable from the next edge.
- R12: A synchronous active-high `rst` clears both counters and both output pipelines. It does not clear the array.
- R13: A write cycle produces no valid read. Whenever `*_rvalid` is 0, `*_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | Static: 0 flow-through, 1 pipelined |
| l_addr | input | AW | Left external address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when invalid |
| l_rvalid | output | 1 | Left read data valid |
| l_wr_n | input | 1 | Left 0 = write, 1 = read |
| l_en_n | input | 1 | Left chip enable, active low |
| l_en2 | input | 1 | Left chip enable, active high |
| l_hi_n | input | 1 | Left upper lane enable (17:9), active low |
| l_lo_n | input | 1 | Left lower lane enable (8:0), active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ld_n | input | 1 | Left address load strobe, active low |
| l_inc_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| r_addr | input | AW | Right external address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when invalid |
| r_rvalid | output | 1 | Right read data valid |
| r_wr_n | input | 1 | Right 0 = write, 1 = read |
| r_en_n | input | 1 | Right chip enable, active low |
| r_en2 | input | 1 | Right chip enable, active high |
| r_hi_n | input | 1 | Right upper lane enable (17:9), active low |
| r_lo_n | input | 1 | Right lower lane enable (8:0), active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ld_n | input | 1 | Right address load strobe, active low |
| r_inc_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |

## Verification
The hardest case to reach is a same-word collision: both ports write one word with partly overlapping lanes while the counters are also moving. With random addresses over the full range, such collisions almost never happen. The stimulus therefore includes directed collisions with mismatched lane masks. It also includes a random mix that often confines addresses to 16 words and applies clear, load and increment together, so that collisions, counter priority and the cross-port read-old-data rule all occur many times. The same mix is repeated in pipelined mode after a block reset, so that deselect and output-enable timing are exercised against the extra stage.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_INC   = 2'd1,
    CTR_LOAD  = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_op_e;

  typedef struct packed {
    logic wr_n;
    logic en_n;
    logic en2;
    logic hi_n;
    logic lo_n;
    logic oe_n;
    logic ld_n;
    logic inc_n;
    logic clr_n;
  } port_ctl_t;

  // Fixed priority: clear over load over increment.
  function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n,
                                         input logic inc_n);
    if (!clr_n)      return CTR_CLEAR;
    else if (!ld_n)  return CTR_LOAD;
    else if (!inc_n) return CTR_INC;
    else             return CTR_HOLD;
  endfunction
endpackage

// File: rtl/bdp_addr_ctr.sv
module bdp_addr_ctr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr
);
  import bdp_pkg::*;

  logic [AW-1:0] cnt_q;
  ctr_op_e       op;

  always_comb begin
    op = ctr_decode(clr_n, ld_n, inc_n);
    unique case (op)
      CTR_CLEAR: acc_addr = '0;
      CTR_LOAD:  acc_addr = ext_addr;
      CTR_INC:   acc_addr = cnt_q + 1'b1;   // wraps at 2^AW
      default:   acc_addr = cnt_q;
    endcase
  end

  // The counter keeps the address used in this cycle.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= acc_addr;
  end
endmodule

// File: rtl/bdp_lane_ram.sv
module bdp_lane_ram #(
  parameter int AW = 11,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wd,
  output logic [W-1:0]  a_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wd,
  output logic [W-1:0]  b_rd
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Port a is written last, so it wins a same-word collision.
  // Reads are read-first: they return the contents before this edge.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (a_we) mem[a_addr] <= a_wd;
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/bdp_read_pipe.sv
module bdp_read_pipe #(
  parameter int DW = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pipe_mode,
  input  logic                      req,
  input  logic [bdp_pkg::LANES-1:0] lane_en,
  input  logic                      oe,
  input  logic [DW-1:0]             raw,
  output logic [DW-1:0]             rdata,
  output logic                      rvalid
);
  import bdp_pkg::*;
  localparam int LW = DW / LANES;

  logic             req_q;
  logic [LANES-1:0] lane_q;
  logic             oe_q;
  logic             st2_v;
  logic [DW-1:0]    st2_d;
  logic [DW-1:0]    mask;
  logic [DW-1:0]    st1_d;
  logic             out_v;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign mask[g*LW +: LW] = {LW{lane_q[g]}};
  end

  assign st1_d = req_q ? (raw & mask) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      lane_q <= '0;
      oe_q   <= 1'b0;
      st2_v  <= 1'b0;
      st2_d  <= '0;
    end else begin
      req_q  <= req;
      lane_q <= lane_en;
      oe_q   <= oe;
      st2_v  <= req_q;
      st2_d  <= st1_d;
    end
  end

  // oe_q holds the enable from the edge that last updated the output.
  assign out_v  = (pipe_mode ? st2_v : req_q) & oe_q;
  assign rvalid = out_v;
  assign rdata  = out_v ? (pipe_mode ? st2_d : st1_d) : '0;
endmodule

// File: rtl/burst_dpram.sv
module burst_dpram #(
  parameter int AW = 11,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          l_wr_n,
  input  logic          l_en_n,
  input  logic          l_en2,
  input  logic          l_hi_n,
  input  logic          l_lo_n,
  input  logic          l_oe_n,
  input  logic          l_ld_n,
  input  logic          l_inc_n,
  input  logic          l_clr_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  input  logic          r_wr_n,
  input  logic          r_en_n,
  input  logic          r_en2,
  input  logic          r_hi_n,
  input  logic          r_lo_n,
  input  logic          r_oe_n,
  input  logic          r_ld_n,
  input  logic          r_inc_n,
  input  logic          r_clr_n
);
  import bdp_pkg::*;
  localparam int LW = DW / LANES;

  port_ctl_t        ctl      [2];
  logic [AW-1:0]    ext_addr [2];
  logic [DW-1:0]    wdata    [2];
  logic [AW-1:0]    acc_addr [2];
  logic             sel      [2];
  logic             wr       [2];
  logic             rd_req   [2];
  logic [LANES-1:0] lane_en  [2];
  logic [DW-1:0]    raw      [2];
  logic [DW-1:0]    rdata    [2];
  logic             rvalid   [2];

  assign ctl[0] = '{wr_n: l_wr_n, en_n: l_en_n, en2: l_en2, hi_n: l_hi_n,
                    lo_n: l_lo_n, oe_n: l_oe_n, ld_n: l_ld_n, inc_n: l_inc_n,
                    clr_n: l_clr_n};
  assign ctl[1] = '{wr_n: r_wr_n, en_n: r_en_n, en2: r_en2, hi_n: r_hi_n,
                    lo_n: r_lo_n, oe_n: r_oe_n, ld_n: r_ld_n, inc_n: r_inc_n,
                    clr_n: r_clr_n};
  assign ext_addr[0] = l_addr;
  assign ext_addr[1] = r_addr;
  assign wdata[0]    = l_wdata;
  assign wdata[1]    = r_wdata;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign sel[p]     = ~ctl[p].en_n & ctl[p].en2;
    assign wr[p]      = sel[p] & ~ctl[p].wr_n;
    assign rd_req[p]  = sel[p] & ctl[p].wr_n;
    assign lane_en[p] = {~ctl[p].hi_n, ~ctl[p].lo_n};

    bdp_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .clr_n    (ctl[p].clr_n),
      .ld_n     (ctl[p].ld_n),
      .inc_n    (ctl[p].inc_n),
      .ext_addr (ext_addr[p]),
      .acc_addr (acc_addr[p])
    );

    bdp_read_pipe #(.DW(DW)) u_rpipe (
      .clk       (clk),
      .rst       (rst),
      .pipe_mode (pipe_mode),
      .req       (rd_req[p]),
      .lane_en   (lane_en[p]),
      .oe        (~ctl[p].oe_n),
      .raw       (raw[p]),
      .rdata     (rdata[p]),
      .rvalid    (rvalid[p])
    );
  end

  // One lane RAM per byte lane; port a is the left port.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bdp_lane_ram #(.AW(AW), .W(LW)) u_lane (
      .clk    (clk),
      .a_we   (wr[0] & lane_en[0][g]),
      .a_addr (acc_addr[0]),
      .a_wd   (wdata[0][g*LW +: LW]),
      .a_rd   (raw[0][g*LW +: LW]),
      .b_we   (wr[1] & lane_en[1][g]),
      .b_addr (acc_addr[1]),
      .b_wd   (wdata[1][g*LW +: LW]),
      .b_rd   (raw[1][g*LW +: LW])
    );
  end

  assign l_rdata  = rdata[0];
  assign l_rvalid = rvalid[0];
  assign r_rdata  = rdata[1];
  assign r_rvalid = rvalid[1];
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int AW = 11,
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          pipe_mode,
  input logic [DW-1:0] l_rdata,
  input logic          l_rvalid,
  input logic          l_wr_n,
  input logic          l_en_n,
  input logic          l_en2,
  input logic          l_oe_n,
  input logic          l_ld_n,
  input logic          l_inc_n,
  input logic          l_clr_n,
  input logic [DW-1:0] r_rdata,
  input logic          r_rvalid,
  input logic          r_wr_n,
  input logic          r_en_n,
  input logic          r_en2,
  input logic          r_oe_n,
  input logic          r_ld_n,
  input logic          r_inc_n,
  input logic          r_clr_n,
  input logic [AW-1:0] acc_addr [2]
);
  assert_l_ft_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && l_rvalid) |-> $past(!l_en_n && l_en2 && l_wr_n && !l_oe_n));
  assert_r_ft_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && r_rvalid) |-> $past(!r_en_n && r_en2 && r_wr_n && !r_oe_n));

  assert_l_pipe_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && l_rvalid) |-> ($past(!l_oe_n) && $past(!l_en_n && l_en2 && l_wr_n, 2)));
  assert_r_pipe_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && r_rvalid) |-> ($past(!r_oe_n) && $past(!r_en_n && r_en2 && r_wr_n, 2)));

  assert_l_ctr_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && l_clr_n && l_ld_n && !l_inc_n) |-> acc_addr[0] == AW'($past(acc_addr[0]) + 1));
  assert_r_ctr_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && r_clr_n && r_ld_n && !r_inc_n) |-> acc_addr[1] == AW'($past(acc_addr[1]) + 1));

  assert_l_ctr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && l_clr_n && l_ld_n && l_inc_n) |-> acc_addr[0] == $past(acc_addr[0]));
  assert_r_ctr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && r_clr_n && r_ld_n && r_inc_n) |-> acc_addr[1] == $past(acc_addr[1]));

  assert_l_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !l_rvalid |-> l_rdata == '0);
  assert_r_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !r_rvalid |-> r_rdata == '0);
endmodule

bind burst_dpram bdp_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/burst_dpram_tb.sv
`timescale 1ns/1ps
module burst_dpram_tb;
  localparam int AW    = 11;
  localparam int DW    = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_mode = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic wr_n [2], en_n [2], en2 [2], hi_n [2], lo_n [2];
  logic oe_n [2], ld_n [2], inc_n [2], clr_n [2];
  logic [DW-1:0] rdata [2];
  logic rvalid [2];

  burst_dpram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode),
    .l_addr(addr[0]), .l_wdata(wdata[0]), .l_rdata(rdata[0]), .l_rvalid(rvalid[0]),
    .l_wr_n(wr_n[0]), .l_en_n(en_n[0]), .l_en2(en2[0]), .l_hi_n(hi_n[0]),
    .l_lo_n(lo_n[0]), .l_oe_n(oe_n[0]), .l_ld_n(ld_n[0]), .l_inc_n(inc_n[0]),
    .l_clr_n(clr_n[0]),
    .r_addr(addr[1]), .r_wdata(wdata[1]), .r_rdata(rdata[1]), .r_rvalid(rvalid[1]),
    .r_wr_n(wr_n[1]), .r_en_n(en_n[1]), .r_en2(en2[1]), .r_hi_n(hi_n[1]),
    .r_lo_n(lo_n[1]), .r_oe_n(oe_n[1]), .r_ld_n(ld_n[1]), .r_inc_n(inc_n[1]),
    .r_clr_n(clr_n[1])
  );

  // Behavioural reference model
  logic [DW-1:0] mem_m [DEPTH];
  int unsigned   cnt_m [2];
  int unsigned   am    [2];
  logic [DW-1:0] msk_m [2];
  bit            s_m   [2];
  bit            ft_v [2], pp_v [2], oe_m [2];
  logic [DW-1:0] ft_d [2], pp_d [2];

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        cnt_m[p] = 0; ft_v[p] = 0; pp_v[p] = 0; oe_m[p] = 0;
        ft_d[p] = '0; pp_d[p] = '0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (!clr_n[p])      am[p] = 0;
        else if (!ld_n[p])  am[p] = addr[p];
        else if (!inc_n[p]) am[p] = (cnt_m[p] + 1) % DEPTH;
        else                am[p] = cnt_m[p];
        cnt_m[p] = am[p];
        s_m[p]   = !en_n[p] && en2[p];
        msk_m[p] = {hi_n[p] ? 9'h000 : 9'h1ff, lo_n[p] ? 9'h000 : 9'h1ff};
        pp_v[p]  = ft_v[p];
        pp_d[p]  = ft_d[p];
        ft_v[p]  = s_m[p] && wr_n[p];
        ft_d[p]  = ft_v[p] ? (mem_m[am[p]] & msk_m[p]) : '0;
        oe_m[p]  = !oe_n[p];
      end
      for (int p = 1; p >= 0; p--) begin   // left applied last: left wins
        if (s_m[p] && !wr_n[p])
          mem_m[am[p]] = (mem_m[am[p]] & ~msk_m[p]) | (wdata[p] & msk_m[p]);
      end
    end
  end

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R12";

  task automatic step();
    bit            ev;
    logic [DW-1:0] ed;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      ev = (pipe_mode ? pp_v[p] : ft_v[p]) && oe_m[p];
      ed = ev ? (pipe_mode ? pp_d[p] : ft_d[p]) : '0;
      checks++;
      if (rvalid[p] !== ev) begin
        fails++;
        $display("FAIL %s port%0d rvalid act=%0b exp=%0b t=%0t", tag, p, rvalid[p], ev, $time);
      end
      checks++;
      if (rdata[p] !== ed) begin
        fails++;
        $display("FAIL %s port%0d rdata act=%h exp=%h t=%0t", tag, p, rdata[p], ed, $time);
      end
    end
  endtask

  task automatic idle(input int p);
    addr[p] = '0; wdata[p] = '0; wr_n[p] = 1; en_n[p] = 0; en2[p] = 1;
    hi_n[p] = 0; lo_n[p] = 0; oe_n[p] = 0; ld_n[p] = 1; inc_n[p] = 1; clr_n[p] = 1;
  endtask

  task automatic idle_both();
    idle(0); idle(1);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 2731 + 341) ^ (i << 7));
  endfunction

  task automatic rd_load(input int p, input int a);
    idle(p); ld_n[p] = 0; addr[p] = AW'(a);
  endtask

  task automatic rand_mix(input int n);
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < 2; p++) begin
        int unsigned r;
        r = $urandom;
        clr_n[p] = (r % 16) != 0;
        ld_n[p]  = ((r >> 4) % 4) != 0;
        inc_n[p] = ((r >> 6) % 2) != 0;
        wr_n[p]  = ((r >> 7) % 3) != 0;
        en_n[p]  = ((r >> 9) % 8) == 0;
        en2[p]   = ((r >> 12) % 8) != 0;
        hi_n[p]  = ((r >> 15) % 4) == 0;
        lo_n[p]  = ((r >> 17) % 4) == 0;
        oe_n[p]  = ((r >> 19) % 6) == 0;
        addr[p]  = ((r >> 22) % 2) != 0 ? AW'($urandom % 16) : AW'($urandom);
        wdata[p] = DW'($urandom);
      end
      step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired during %s", tag);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle_both();
    // R12: outputs idle during and right after reset
    tag = "R12";
    step(); step(); step();
    rst = 0;
    idle_both(); wr_n[0] = 1; en_n[0] = 1; en_n[1] = 1;
    step();

    // R1: fill the whole array in bursts, left low half, right high half
    tag = "R1";
    for (int i = 0; i < DEPTH / 2; i++) begin
      for (int p = 0; p < 2; p++) begin
        idle(p); wr_n[p] = 0;
        if (i == 0) begin ld_n[p] = 0; addr[p] = AW'(p * DEPTH / 2); end
        else inc_n[p] = 0;
        wdata[p] = pat(p * DEPTH / 2 + i);
      end
      step();
    end
    // R1/R6: loaded reads on both ports, some on the same word
    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      rd_load(0, (i * 97) % DEPTH);
      rd_load(1, (i % 3 == 0) ? (i * 97) % DEPTH : (i * 53 + 11) % DEPTH);
      step();
    end

    // R2: priority between clear, load and increment
    tag = "R2";
    rd_load(0, 100); rd_load(1, 200); step();
    idle_both(); inc_n[0] = 0; inc_n[1] = 0; step();
    idle_both(); step();
    idle_both(); clr_n[0] = 0; ld_n[0] = 0; addr[0] = 50; inc_n[0] = 0;
    ld_n[1] = 0; addr[1] = 60; inc_n[1] = 0; step();
    idle_both(); inc_n[0] = 0; inc_n[1] = 0; step();

    // R4: clear with access, then incrementing accesses 1, 2, 3
    tag = "R4";
    idle_both(); clr_n[0] = 0; clr_n[1] = 0; step();
    for (int i = 0; i < 3; i++) begin idle_both(); inc_n[0] = 0; inc_n[1] = 0; step(); end
    idle_both(); clr_n[0] = 0; wr_n[0] = 0; wdata[0] = 18'h2aaaa; step();
    idle_both(); inc_n[0] = 0; rd_load(1, 0); step();

    // R5: wrap of the counter at the top word
    tag = "R5";
    rd_load(0, DEPTH - 2); rd_load(1, DEPTH - 1); step();
    for (int i = 0; i < 3; i++) begin idle_both(); inc_n[0] = 0; inc_n[1] = 0; step(); end

    // R9: lane-masked writes and reads
    tag = "R9";
    rd_load(0, 5); wr_n[0] = 0; hi_n[0] = 1; wdata[0] = 18'h3ffff;
    rd_load(1, 6); wr_n[1] = 0; lo_n[1] = 1; wdata[1] = 18'h3ffff; step();
    rd_load(0, 5); rd_load(1, 6); step();
    rd_load(0, 5); lo_n[0] = 1; rd_load(1, 6); hi_n[1] = 1; step();
    rd_load(0, 5); lo_n[0] = 1; hi_n[0] = 1; rd_load(1, 6); step();

    // R8: deselected writes and reads
    tag = "R8";
    rd_load(0, 7); wr_n[0] = 0; en_n[0] = 1; wdata[0] = 18'h11111;
    rd_load(1, 8); wr_n[1] = 0; en2[1] = 0; wdata[1] = 18'h22222; step();
    rd_load(0, 7); en_n[0] = 1; rd_load(1, 8); en2[1] = 0; step();
    rd_load(0, 7); rd_load(1, 8); step();

    // R10: output enable off while reads continue
    tag = "R10";
    for (int i = 0; i < 6; i++) begin
      rd_load(0, 20 + i); oe_n[0] = i[0];
      rd_load(1, 30 + i); oe_n[1] = !i[0];
      step();
    end

    // R11: same-word collisions and cross-port visibility
    tag = "R11";
    rd_load(0, 9); wr_n[0] = 0; wdata[0] = 18'h0aaaa;
    rd_load(1, 9); wr_n[1] = 0; wdata[1] = 18'h35555; step();
    rd_load(0, 9); rd_load(1, 9); step();
    rd_load(0, 10); wr_n[0] = 0; hi_n[0] = 1; wdata[0] = 18'h00f0f;
    rd_load(1, 10); wr_n[1] = 0; wdata[1] = 18'h3c3c3; step();
    rd_load(0, 11); wr_n[0] = 0; wdata[0] = 18'h12345; rd_load(1, 11); step();
    rd_load(0, 10); rd_load(1, 11); step();

    // R13: write cycles give no valid output
    tag = "R13";
    for (int i = 0; i < 4; i++) begin
      rd_load(0, 40 + i); wr_n[0] = 0; wdata[0] = pat(i + 7);
      rd_load(1, 50 + i); wr_n[1] = 0; wdata[1] = pat(i + 9);
      step();
    end

    // R3: random mix in flow-through mode
    tag = "R3";
    rand_mix(1500);

    // R12: block reset, switch to pipelined mode
    tag = "R12";
    idle_both(); rst = 1; step(); pipe_mode = 1; step();
    rst = 0;
    idle_both(); inc_n[0] = 0; inc_n[1] = 0; step();
    idle_both(); step(); step();

    // R7: pipelined timing, including deselect and output enable
    tag = "R7";
    for (int i = 0; i < 8; i++) begin
      rd_load(0, 60 + i); en_n[0] = (i == 3); oe_n[0] = (i == 5);
      rd_load(1, 70 + i); en2[1] = (i != 2);
      step();
    end
    tag = "R8";
    rand_mix(1500);
    idle_both(); step(); step();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule